// File: doc/BRIEF.md
# CAN receive acceptance mask filter

This block decides whether an incoming CAN identifier is accepted by one receive message buffer or by one element of the receive FIFO filter table. Each request names a target. The target is either a buffer index or a FIFO element index. The request also carries the received ID, IDE and RTR bits and the stored filter word for that target. The block picks the acceptance mask that applies to the target, limits it to the fields that the target type compares, and performs a masked bitwise compare. The `match` result is combinational in the same cycle as `req_valid`.

The block holds three 32-bit mask registers: a global mask and two legacy masks that belong to buffers 14 and 15. When the receive FIFO is enabled, the same two legacy masks also serve FIFO filter elements 6 and 7. An individual-masking mode bit replaces all of this selection with a per-request mask input, so that the legacy registers no longer matter. A small register port writes and reads the masks. Writes only land while the block is frozen.

Top module: `can_accept_filter`

## Requirements
- R1: Both the received word and the filter word use this layout: bit 31 is RTR, bit 30 is IDE, bit 29 is unused, and bits 28:0 are the identifier. `match` is 1 exactly when no bit that is set in the effective mask differs between the two words. A mask bit of 0 makes that bit don't-care.
- R2: For a message-buffer request (`req_is_fifo`=0), the effective mask covers identifier bits 28:0 only. IDE and RTR never affect the result.
- R3: For a FIFO element request (`req_is_fifo`=1 with `fifo_en`=1), the effective mask covers the identifier, IDE and RTR together. Bit 29 is never compared.
- R4: With `indiv_mask_en`=0, buffer 14 uses the MB14 mask, buffer 15 uses the MB15 mask, and every other buffer uses the global mask.
- R5: With `indiv_mask_en`=0 and `fifo_en`=1, FIFO element 6 uses the MB14 mask, element 7 uses the MB15 mask, and all other elements use the global mask.
- R6: With `indiv_mask_en`=1, every compare uses `indiv_mask`, and the MB14 and MB15 masks have no effect.
- R7: A FIFO element request while `fifo_en`=0 never matches.
- R8: `match` is 0 whenever `req_valid` is 0. With `req_valid` at 1, `match` reflects the inputs in the same cycle.
- R9: After reset, all three masks read 0xFFFF_FFFF. `reg_rdata` returns the global mask at offset 0x10, the MB14 mask at 0x14, the MB15 mask at 0x18, and 0 at any other offset.
- R10: A write (`reg_wr_en`=1) changes the addressed mask at the clock edge only while `freeze`=1. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Freeze mode; enables mask writes |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_addr | input | 8 | Register offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| indiv_mask_en | input | 1 | Individual per-buffer masking mode |
| fifo_en | input | 1 | Receive FIFO enabled |
| req_valid | input | 1 | Compare request strobe |
| req_is_fifo | input | 1 | 1: FIFO filter element, 0: message buffer |
| req_index | input | 6 | Buffer index or filter element index |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received IDE bit |
| rx_rtr | input | 1 | Received RTR bit |
| filt_word | input | 32 | Stored filter word of the target |
| indiv_mask | input | 32 | Per-buffer mask used in individual mode |
| match | output | 1 | Acceptance result |

## Verification
The bench programs three distinct masks, so that every selection path gives a different answer for the same identifier.

- **Legacy mask routing.** If the 14/15 routing or the FIFO 6/7 routing were swapped, or fell back to the global mask, one of the paired vectors would flip.
- **Field limits.** Buffer requests carry IDE/RTR mismatches that must be ignored, and FIFO requests carry mismatches that must reject. A field limit applied to the wrong target type therefore shows up in both directions.
- **Individual mode.** Individual mode is tried on buffer 14 and FIFO element 7. A design that still used the legacy masks there would accept frames it should reject.
- **Register port.** A write outside freeze must leave the read-back value unchanged. FIFO requests with the FIFO disabled must not match.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int WORD_W  = 32;
  localparam int ID_W    = 29;
  localparam int IDE_POS = 30;
  localparam int RTR_POS = 31;

  // Fields compared per target type
  localparam logic [WORD_W-1:0] MB_FIELDS   = 32'h1FFF_FFFF;
  localparam logic [WORD_W-1:0] FIFO_FIELDS = 32'hDFFF_FFFF;

  typedef enum logic [1:0] {
    SRC_GLOBAL = 2'd0,
    SRC_LEG_A  = 2'd1,
    SRC_LEG_B  = 2'd2,
    SRC_INDIV  = 2'd3
  } mask_src_e;

  function automatic logic [WORD_W-1:0] pack_rx(input logic [ID_W-1:0] id,
                                                input logic ide,
                                                input logic rtr);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ID_W-1:0] = id;
    w[IDE_POS]  = ide;
    w[RTR_POS]  = rtr;
    return w;
  endfunction

  function automatic logic masked_equal(input logic [WORD_W-1:0] a,
                                        input logic [WORD_W-1:0] b,
                                        input logic [WORD_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction
endpackage

// File: rtl/can_mask_regs.sv
module can_mask_regs
  import can_acc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_GLOBAL = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_LEG_A  = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_LEG_B  = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] global_mask,
  output logic [WORD_W-1:0] leg_a_mask,
  output logic [WORD_W-1:0] leg_b_mask
);
  localparam int NREG = 3;
  localparam logic [ADDR_W-1:0] OFS [NREG] = '{OFS_GLOBAL, OFS_LEG_A, OFS_LEG_B};

  logic [WORD_W-1:0] mask_q [NREG];
  logic [NREG-1:0]   hit;
  logic              wr_allowed;

  assign wr_allowed = wr_en && freeze;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = (addr == OFS[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q[g] <= '1;
      else if (wr_allowed && hit[g]) mask_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rdata = mask_q[i];
  end

  assign global_mask = mask_q[0];
  assign leg_a_mask  = mask_q[1];
  assign leg_b_mask  = mask_q[2];

  // R10: outside freeze, no mask moves
  a_r10_frozen_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> ($stable(global_mask) && $stable(leg_a_mask) && $stable(leg_b_mask)));
endmodule

// File: rtl/can_mask_select.sv
module can_mask_select
  import can_acc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LEG_MB_A   = 14,
  parameter int LEG_MB_B   = 15,
  parameter int LEG_FIFO_A = 6,
  parameter int LEG_FIFO_B = 7
) (
  input  logic              indiv_en,
  input  logic              fifo_en,
  input  logic              is_fifo,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] global_mask,
  input  logic [WORD_W-1:0] leg_a_mask,
  input  logic [WORD_W-1:0] leg_b_mask,
  input  logic [WORD_W-1:0] indiv_mask,
  output mask_src_e         src,
  output logic              target_ok,
  output logic [WORD_W-1:0] eff_mask
);
  localparam logic [IDX_W-1:0] IA_MB   = IDX_W'(LEG_MB_A);
  localparam logic [IDX_W-1:0] IB_MB   = IDX_W'(LEG_MB_B);
  localparam logic [IDX_W-1:0] IA_FIFO = IDX_W'(LEG_FIFO_A);
  localparam logic [IDX_W-1:0] IB_FIFO = IDX_W'(LEG_FIFO_B);

  logic [IDX_W-1:0]  leg_a_idx, leg_b_idx;
  logic [WORD_W-1:0] raw_mask, field_mask;

  assign leg_a_idx = is_fifo ? IA_FIFO : IA_MB;
  assign leg_b_idx = is_fifo ? IB_FIFO : IB_MB;
  assign target_ok = !is_fifo || fifo_en;

  always_comb begin
    if (indiv_en)               src = SRC_INDIV;
    else if (idx == leg_a_idx)  src = SRC_LEG_A;
    else if (idx == leg_b_idx)  src = SRC_LEG_B;
    else                        src = SRC_GLOBAL;
  end

  always_comb begin
    unique case (src)
      SRC_INDIV: raw_mask = indiv_mask;
      SRC_LEG_A: raw_mask = leg_a_mask;
      SRC_LEG_B: raw_mask = leg_b_mask;
      default:   raw_mask = global_mask;
    endcase
  end

  assign field_mask = is_fifo ? FIFO_FIELDS : MB_FIELDS;
  assign eff_mask   = raw_mask & field_mask;
endmodule

// File: rtl/can_masked_compare.sv
module can_masked_compare
  import can_acc_pkg::*;
(
  input  logic              enable,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] filt_word,
  input  logic [WORD_W-1:0] eff_mask,
  output logic              hit
);
  logic equal_w;
  assign equal_w = masked_equal(rx_word, filt_word, eff_mask);
  assign hit     = enable && equal_w;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 6,
  parameter logic [ADDR_W-1:0] OFS_GLOBAL = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_LEG_A  = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_LEG_B  = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              indiv_mask_en,
  input  logic              fifo_en,
  input  logic              req_valid,
  input  logic              req_is_fifo,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [28:0]       rx_id,
  input  logic              rx_ide,
  input  logic              rx_rtr,
  input  logic [31:0]       filt_word,
  input  logic [31:0]       indiv_mask,
  output logic              match
);
  logic [WORD_W-1:0] gmask, amask, bmask, eff_mask, rx_word;
  mask_src_e         src;
  logic              target_ok, cmp_en;

  can_mask_regs #(
    .ADDR_W(ADDR_W), .OFS_GLOBAL(OFS_GLOBAL),
    .OFS_LEG_A(OFS_LEG_A), .OFS_LEG_B(OFS_LEG_B)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_en(reg_wr_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .global_mask(gmask), .leg_a_mask(amask), .leg_b_mask(bmask)
  );

  can_mask_select #(.IDX_W(IDX_W)) u_sel (
    .indiv_en(indiv_mask_en), .fifo_en(fifo_en), .is_fifo(req_is_fifo),
    .idx(req_index), .global_mask(gmask), .leg_a_mask(amask),
    .leg_b_mask(bmask), .indiv_mask(indiv_mask), .src(src),
    .target_ok(target_ok), .eff_mask(eff_mask)
  );

  assign rx_word = pack_rx(rx_id, rx_ide, rx_rtr);
  assign cmp_en  = req_valid && target_ok;

  can_masked_compare u_cmp (
    .enable(cmp_en), .rx_word(rx_word), .filt_word(filt_word),
    .eff_mask(eff_mask), .hit(match)
  );

  // R8: no request, no acceptance
  a_r8_idle_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !match);

  // R7: FIFO target while FIFO is off
  a_r7_fifo_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_fifo && !fifo_en) |-> !match);

  // R2: buffer compares never look at IDE/RTR
  a_r2_mb_id_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_fifo) |-> (eff_mask[31:29] == 3'b000));

  // R6: individual mode follows the per-request mask
  a_r6_indiv_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && indiv_mask_en && !req_is_fifo) |-> (eff_mask[28:0] == indiv_mask[28:0]));

  // R1: with every ID bit checked, acceptance means an exact ID match
  a_r1_full_mask_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !req_is_fifo && (eff_mask[28:0] == '1)) |-> (rx_id == filt_word[28:0]));
endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        freeze = 0, reg_wr_en = 0;
  logic [7:0]  reg_addr = 8'h10;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        indiv_mask_en = 0, fifo_en = 0, req_valid = 0, req_is_fifo = 0;
  logic [5:0]  req_index = '0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 0, rx_rtr = 0;
  logic [31:0] filt_word = '0, indiv_mask = '0;
  logic        match;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_accept_filter i_can_accept_filter (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .indiv_mask_en(indiv_mask_en), .fifo_en(fifo_en), .req_valid(req_valid),
    .req_is_fifo(req_is_fifo), .req_index(req_index), .rx_id(rx_id),
    .rx_ide(rx_ide), .rx_rtr(rx_rtr), .filt_word(filt_word),
    .indiv_mask(indiv_mask), .match(match)
  );

  // Vector: {indiv, fifo_en, is_fifo, idx[6], id[29], ide, rtr, filt[32], imask[32], exp}
  localparam int VW = 105;
  localparam int NV = 16;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,6'd3, 29'h0000123, 1'b0,1'b0,32'h0000_0100,32'h0,1'b1},          // R4 global ignores low byte
    {1'b0,1'b0,1'b0,6'd3, 29'h0001123, 1'b0,1'b0,32'h0000_0123,32'h0,1'b0},          // R1 checked bit differs
    {1'b0,1'b0,1'b0,6'd14,29'h0001123, 1'b0,1'b0,32'h0000_0123,32'h0,1'b1},          // R4 MB14 mask
    {1'b0,1'b0,1'b0,6'd14,29'h0010123, 1'b0,1'b0,32'h0000_0123,32'h0,1'b0},          // R4 MB14 checks bit16
    {1'b0,1'b0,1'b0,6'd15,29'h1ABCDEF, 1'b0,1'b0,32'h0000_0000,32'h0,1'b1},          // R4 MB15 mask zero
    {1'b0,1'b0,1'b0,6'd3, 29'h0000100, 1'b1,1'b1,32'h0000_0100,32'h0,1'b1},          // R2 IDE/RTR ignored
    {1'b0,1'b1,1'b1,6'd2, 29'h0000100, 1'b1,1'b0,32'h0000_0100,32'h0,1'b0},          // R3 IDE compared
    {1'b0,1'b1,1'b1,6'd2, 29'h0000100, 1'b1,1'b0,32'h4000_0100,32'h0,1'b1},          // R3 IDE equal
    {1'b0,1'b1,1'b1,6'd6, 29'h0001123, 1'b0,1'b0,32'h0000_0123,32'h0,1'b1},          // R5 elem6 MB14 mask
    {1'b0,1'b1,1'b1,6'd7, 29'h1ABCDEF, 1'b0,1'b1,32'h0000_0000,32'h0,1'b1},          // R5 elem7 MB15 mask
    {1'b0,1'b1,1'b1,6'd6, 29'h0000000, 1'b0,1'b1,32'h0000_0000,32'h0,1'b0},          // R3 RTR compared
    {1'b0,1'b1,1'b1,6'd2, 29'h0000100, 1'b0,1'b0,32'h2000_0100,32'h0,1'b1},          // R3 bit29 unused
    {1'b1,1'b1,1'b1,6'd7, 29'h0000005, 1'b0,1'b0,32'h0000_0000,32'hFFFF_FFFF,1'b0},  // R6 FIFO legacy off
    {1'b1,1'b0,1'b0,6'd14,29'h0001123, 1'b0,1'b0,32'h0000_0123,32'hFFFF_FFFF,1'b0},  // R6 MB14 legacy off
    {1'b1,1'b0,1'b0,6'd3, 29'h1FFFFFFF,1'b0,1'b0,32'h0000_0000,32'h0000_0000,1'b1},  // R6 indiv mask zero
    {1'b0,1'b0,1'b1,6'd6, 29'h0000000, 1'b0,1'b0,32'h0000_0000,32'h0,1'b0}           // R7 FIFO disabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2 check(req, reg_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #2 check("R9 reset rdata global", reg_rdata, 32'hFFFF_FFFF);
    rst_n = 1;
    read_check("R9 reset global", 8'h10, 32'hFFFF_FFFF);
    read_check("R9 reset mb14", 8'h14, 32'hFFFF_FFFF);
    read_check("R9 reset mb15", 8'h18, 32'hFFFF_FFFF);
    read_check("R9 unmapped reads 0", 8'h1C, 32'h0);
    @(negedge clk);
    #2 check("R8 idle no match", {31'b0, match}, 32'h0);

    // R10: write outside freeze is ignored
    reg_write(8'h10, 32'h1234_5678);
    read_check("R10 write without freeze ignored", 8'h10, 32'hFFFF_FFFF);

    freeze = 1;
    reg_write(8'h10, 32'hDFFF_FF00);
    reg_write(8'h14, 32'hDFFF_0000);
    reg_write(8'h18, 32'h0000_0000);
    freeze = 0;
    read_check("R10 global written in freeze", 8'h10, 32'hDFFF_FF00);
    read_check("R9 mb14 offset", 8'h14, 32'hDFFF_0000);
    read_check("R9 mb15 offset", 8'h18, 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      indiv_mask_en = v[104]; fifo_en = v[103]; req_is_fifo = v[102];
      req_index = v[101:96]; rx_id = v[95:67]; rx_ide = v[66]; rx_rtr = v[65];
      filt_word = v[64:33]; indiv_mask = v[32:1]; req_valid = 1;
      #2 check($sformatf("R1 vector %0d", i), {31'b0, match}, {31'b0, v[0]});
    end

    // R8: a matching setup with valid low gives no match
    @(negedge clk);
    indiv_mask_en = 0; fifo_en = 0; req_is_fifo = 0; req_index = 6'd15;
    rx_id = 29'h5; filt_word = 32'h0; req_valid = 0;
    #2 check("R8 valid low blocks match", {31'b0, match}, 32'h0);
    req_valid = 1;
    #2 check("R8 same-cycle match", {31'b0, match}, 32'h1);

    // R7: the same element matches once the FIFO is enabled
    @(negedge clk);
    req_is_fifo = 1; req_index = 6'd7; rx_id = 29'h5;
    #2 check("R7 fifo off", {31'b0, match}, 32'h0);
    fifo_en = 1;
    #2 check("R5 fifo on elem7", {31'b0, match}, 32'h1);

    // R10: a further non-freeze write leaves the MB15 mask and the result unchanged
    req_valid = 0;
    reg_write(8'h18, 32'hFFFF_FFFF);
    read_check("R10 mb15 unchanged", 8'h18, 32'h0000_0000);
    req_valid = 1;
    #2 check("R10 filtering unchanged", {31'b0, match}, 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule